// File: doc/BRIEF.md
# Multi-Lane Main-Link Scrambler with Staggered Lane Skew

This block sits between a link's symbol source and its per-lane 8b/10b encoders. Each clock it accepts one byte per lane, with a flag that marks the byte as a control symbol. Data bytes are whitened by a per-lane 16-bit scrambler. Control bytes pass through unchanged. Each lane's result is then delayed by a fixed number of symbol clocks, so adjacent lanes leave the block two symbols apart. The offset pattern repeats for every group of four lanes. A bank may carry from one to sixteen lanes.

Each lane is controlled by a two-state machine. State `LN_OFF` holds the scrambler at its seed of 16'hFFFE and emits idle zero symbols. State `LN_RUN` scrambles live traffic. The transition `lane_up` (LN_OFF to LN_RUN) is taken when the lane index is below the active lane count. The transition `lane_down` (LN_RUN to LN_OFF) is taken when it is not. A shared scrambler-reset strobe marks a cycle in which every running lane forwards its byte unscrambled and reloads its seed. This keeps all lanes in step.

Top module: `mlane_scramble_skew`

## Requirements
- R1: While reset is asserted, every lane outputs byte 8'h00 with the control flag low, every lane is in LN_OFF, and every scrambler holds 16'hFFFE.
- R2: In LN_RUN, a data byte (flag 0) leaves as the byte XOR an 8-bit keystream. The keystream comes from eight steps of the lane's 16-bit register S. At step b (b = 0 first, giving keystream bit b, LSB first), the keystream bit is S[15]. S then becomes (S << 1) XOR 16'h0039 if that bit was 1, else S << 1. The register keeps the state after eight steps.
- R3: In LN_RUN, a control byte (flag 1) leaves unchanged with its flag set. The scrambler still advances eight steps.
- R4: In a cycle with the scrambler-reset strobe high, every lane in LN_RUN forwards its byte and flag unchanged and reloads 16'hFFFE. The next data byte on that lane is scrambled with the keystream of the seed.
- R5: A lane in LN_OFF outputs byte 8'h00 with flag 0 and reloads 16'hFFFE. After lane_up, its first data byte uses the keystream of the seed.
- R6: The output of lane i lags its input by 1 + 2*(i mod 4) clock cycles.
- R7: The lane state is loaded from the active lane count with one cycle of latency. A count of 0 stops every lane, and a count of 16 or more runs every lane.
- R8: Lanes scramble independently. Lanes that start from the seed with equal input bytes produce equal scrambled bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_count | input | 5 | Number of active lanes, 0 to 31 |
| scr_reset | input | 1 | Scrambler-reset strobe for all lanes |
| in_bytes | input | 128 | Input byte per lane, lane i in bits 8i+7:8i |
| in_ctrl | input | 16 | Control flag per lane |
| out_bytes | output | 128 | Scrambled, skewed byte per lane |
| out_ctrl | output | 16 | Skewed control flag per lane |

## Verification
Two functions can act in the same cycle: the scrambler-reset strobe, and a lane_down or lane_up transition caused by a change in the lane count. The bench raises the strobe in the same cycle that it lowers the lane count, and again in the cycle where the lane count is raised. It then checks, on every lane, the symbols that follow each event. A running lane must reseed and pass its byte through. A stopped lane must emit zeros. A restarted lane must begin from the seed keystream. The outputs are judged against a per-lane model built from the requirements. The model keeps each lane's skew delay, so the check on each lane is made at the cycle its delayed output appears.

// File: rtl/mlss_pkg.sv
package mlss_pkg;

    typedef enum logic [0:0] {
        LN_OFF = 1'b0,
        LN_RUN = 1'b1
    } lane_mode_e;

    // Symbol delay of a lane: step times the lane's position inside its group
    function automatic int lane_skew(input int idx, input int step, input int group);
        return step * (idx % group);
    endfunction

endpackage

// File: rtl/lane_scrambler.sv
module lane_scrambler
    import mlss_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] POLY_MASK = 16'h0039,
    parameter logic [LFSR_W-1:0] SEED      = 16'hFFFE,
    parameter int                LANE_IDX  = 0,
    parameter int                CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  lane_count,
    input  logic              scr_reset,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_ctrl
);

    localparam logic [CNT_W:0] IDX_V = (CNT_W+1)'(LANE_IDX);

    lane_mode_e        state_q, state_d;
    logic              lane_on;
    logic [LFSR_W-1:0] lfsr_q, lfsr_walk;
    logic [BYTE_W-1:0] ks;
    logic [BYTE_W-1:0] byte_q;
    logic              ctrl_q;

    assign lane_on = ({1'b0, lane_count} > IDX_V);

    // Next-state logic: lane_up / lane_down
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF: if (lane_on)  state_d = LN_RUN;
            LN_RUN: if (!lane_on) state_d = LN_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_OFF;
        else        state_q <= state_d;
    end

    // Keystream: one byte from eight Galois steps
    always_comb begin
        ks        = '0;
        lfsr_walk = lfsr_q;
        for (int b = 0; b < BYTE_W; b++) begin
            ks[b]     = lfsr_walk[LFSR_W-1];
            lfsr_walk = {lfsr_walk[LFSR_W-2:0], 1'b0}
                        ^ (lfsr_walk[LFSR_W-1] ? POLY_MASK : '0);
        end
    end

    // Output and scrambler register, per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            byte_q <= '0;
            ctrl_q <= 1'b0;
        end else begin
            unique case (state_q)
                LN_OFF: begin
                    lfsr_q <= SEED;
                    byte_q <= '0;
                    ctrl_q <= 1'b0;
                end
                LN_RUN: begin
                    byte_q <= (scr_reset || in_ctrl) ? in_byte : (in_byte ^ ks);
                    ctrl_q <= in_ctrl;
                    lfsr_q <= scr_reset ? SEED : lfsr_walk;
                end
            endcase
        end
    end

    assign out_byte = byte_q;
    assign out_ctrl = ctrl_q;

    // R5: a stopped lane emits idle zeros
    a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_OFF) |=> (byte_q == '0 && !ctrl_q));

    // R5: a stopped lane sits at the seed
    a_r5_off_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_OFF) |=> (lfsr_q == SEED));

    // R3: control symbols leave unchanged
    a_r3_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_RUN && in_ctrl) |=> (byte_q == $past(in_byte) && ctrl_q));

    // R4: the reset strobe reloads the seed
    a_r4_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        scr_reset |=> (lfsr_q == SEED));

    // R7: the lane state follows the lane count one cycle later
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        lane_on |=> (state_q == LN_RUN));

endmodule

// File: rtl/lane_delay.sv
module lane_delay #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_shift
            logic [W-1:0] pipe [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
                end
            end
            assign dout = pipe[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mlane_scramble_skew.sv
module mlane_scramble_skew
    import mlss_pkg::*;
#(
    parameter int                NUM_LANES  = 16,
    parameter int                BYTE_W     = 8,
    parameter int                LFSR_W     = 16,
    parameter logic [LFSR_W-1:0] POLY_MASK  = 16'h0039,
    parameter logic [LFSR_W-1:0] SEED       = 16'hFFFE,
    parameter int                SKEW_STEP  = 2,
    parameter int                SKEW_GROUP = 4,
    localparam int               CNT_W      = $clog2(NUM_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            lane_count,
    input  logic                        scr_reset,
    input  logic [NUM_LANES*BYTE_W-1:0] in_bytes,
    input  logic [NUM_LANES-1:0]        in_ctrl,
    output logic [NUM_LANES*BYTE_W-1:0] out_bytes,
    output logic [NUM_LANES-1:0]        out_ctrl
);

    localparam int SYM_W = BYTE_W + 1;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int DEPTH = lane_skew(g, SKEW_STEP, SKEW_GROUP);

        logic [BYTE_W-1:0] s_byte;
        logic              s_ctrl;
        logic [SYM_W-1:0]  d_sym;

        lane_scrambler #(
            .BYTE_W    (BYTE_W),
            .LFSR_W    (LFSR_W),
            .POLY_MASK (POLY_MASK),
            .SEED      (SEED),
            .LANE_IDX  (g),
            .CNT_W     (CNT_W)
        ) u_scr (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_count (lane_count),
            .scr_reset  (scr_reset),
            .in_byte    (in_bytes[g*BYTE_W +: BYTE_W]),
            .in_ctrl    (in_ctrl[g]),
            .out_byte   (s_byte),
            .out_ctrl   (s_ctrl)
        );

        lane_delay #(
            .W     (SYM_W),
            .DEPTH (DEPTH)
        ) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   ({s_ctrl, s_byte}),
            .dout  (d_sym)
        );

        assign out_bytes[g*BYTE_W +: BYTE_W] = d_sym[BYTE_W-1:0];
        assign out_ctrl[g]                   = d_sym[BYTE_W];
    end

endmodule

// File: tb/mlane_scramble_skew_bench.sv
`timescale 1ns/1ps
module mlane_scramble_skew_bench;

    localparam int NL = 16;
    localparam int BW = 8;
    localparam int CW = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CW-1:0]    lane_count = '0;
    logic             scr_reset = 1'b0;
    logic [NL*BW-1:0] in_bytes = '0;
    logic [NL-1:0]    in_ctrl = '0;
    logic [NL*BW-1:0] out_bytes;
    logic [NL-1:0]    out_ctrl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mlane_scramble_skew u_mlane_scramble_skew (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_count (lane_count),
        .scr_reset  (scr_reset),
        .in_bytes   (in_bytes),
        .in_ctrl    (in_ctrl),
        .out_bytes  (out_bytes),
        .out_ctrl   (out_ctrl)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [7:0] ks_of(input logic [15:0] s);
        logic [7:0] k;
        for (int b = 0; b < 8; b++) begin
            k[b] = s[15];
            s = {s[14:0], 1'b0} ^ (k[b] ? 16'h0039 : 16'h0000);
        end
        return k;
    endfunction

    function automatic logic [15:0] adv_of(input logic [15:0] s);
        for (int b = 0; b < 8; b++) begin
            s = {s[14:0], 1'b0} ^ (s[15] ? 16'h0039 : 16'h0000);
        end
        return s;
    endfunction

    function automatic int lat_of(input int l);
        return 2 * (l % 4);
    endfunction

    logic [15:0] m_lfsr [NL];
    logic        m_on   [NL];
    logic [8:0]  m_hist [NL][7];

    always @(posedge clk) begin
        for (int l = 0; l < NL; l++) begin
            logic [8:0] st;
            logic [7:0] b;
            if (!rst_n) begin
                m_lfsr[l] = 16'hFFFE;
                m_on[l]   = 1'b0;
                for (int k = 0; k < 7; k++) m_hist[l][k] = '0;
            end else begin
                b = in_bytes[l*8 +: 8];
                if (!m_on[l]) begin
                    st = '0;
                    m_lfsr[l] = 16'hFFFE;
                end else if (scr_reset) begin
                    st = {in_ctrl[l], b};
                    m_lfsr[l] = 16'hFFFE;
                end else if (in_ctrl[l]) begin
                    st = {1'b1, b};
                    m_lfsr[l] = adv_of(m_lfsr[l]);
                end else begin
                    st = {1'b0, b ^ ks_of(m_lfsr[l])};
                    m_lfsr[l] = adv_of(m_lfsr[l]);
                end
                for (int k = 6; k > 0; k--) m_hist[l][k] = m_hist[l][k-1];
                m_hist[l][0] = st;
                m_on[l] = (int'(lane_count) > l);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [8:0] lane_out(input int l);
        return {out_ctrl[l], out_bytes[l*8 +: 8]};
    endfunction

    task automatic check_model(input string tag);
        for (int l = 0; l < NL; l++)
            check_eq($sformatf("%s model lane %0d", tag, l), lane_out(l), m_hist[l][lat_of(l)]);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        #1;
        check_model(tag);
    endtask

    task automatic put_pat(input int c, input logic [NL-1:0] ctrl, input logic srst);
        for (int l = 0; l < NL; l++) in_bytes[l*8 +: 8] = 8'((c * 37) + (l * 11) + 5);
        in_ctrl   = ctrl;
        scr_reset = srst;
    endtask

    task automatic put_all(input logic [7:0] b, input logic [NL-1:0] ctrl, input logic srst);
        for (int l = 0; l < NL; l++) in_bytes[l*8 +: 8] = b;
        in_ctrl   = ctrl;
        scr_reset = srst;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();   // R1
        for (int l = 0; l < NL; l++)
            check_eq($sformatf("R1 reset lane %0d", l), lane_out(l), 9'h000);
    endtask

    task automatic t_first_data();   // R2, R8
        lane_count = 5'd16;
        put_all(8'h00, '0, 1'b0);
        step("R7 enable");
        put_all(8'h3C, '0, 1'b0);
        step("R2 first");
        check_eq("R2 lane0 seed keystream", lane_out(0), {1'b0, 8'h3C ^ ks_of(16'hFFFE)});
        check_eq("R8 lane4 equals lane0", lane_out(4), lane_out(0));
        for (int c = 0; c < 20; c++) begin
            put_pat(c, '0, 1'b0);
            step("R2 data stream");
        end
    endtask

    task automatic t_ctrl();   // R3
        put_all(8'hBC, '1, 1'b0);
        step("R3 ctrl");
        check_eq("R3 lane0 ctrl unchanged", lane_out(0), {1'b1, 8'hBC});
        for (int c = 0; c < 20; c++) begin
            put_pat(c + 100, NL'(16'h5A3C ^ (c * 16'h1111)), 1'b0);
            step("R3 mixed");
        end
    endtask

    task automatic t_reseed();   // R4
        put_all(8'h77, '0, 1'b1);
        step("R4 strobe");
        check_eq("R4 strobe byte unscrambled", lane_out(0), {1'b0, 8'h77});
        put_all(8'h3C, '0, 1'b0);
        step("R4 after strobe");
        check_eq("R4 seed keystream after strobe", lane_out(4), {1'b0, 8'h3C ^ ks_of(16'hFFFE)});
        for (int c = 0; c < 8; c++) begin
            put_pat(c + 200, '0, 1'b0);
            step("R4 drain");
        end
    endtask

    task automatic t_lanes();   // R5, R7, with the strobe in the same cycles
        lane_count = 5'd2;
        put_pat(300, '0, 1'b1);
        step("R5 shrink with strobe");
        put_pat(301, '0, 1'b0);
        step("R5 shrunk");
        check_eq("R5 lane4 idle", lane_out(4), 9'h000);
        for (int c = 0; c < 8; c++) begin
            put_pat(c + 310, '0, 1'b0);
            step("R5 shrunk run");
        end
        lane_count = 5'd20;
        put_pat(320, '0, 1'b1);
        step("R7 grow with strobe");
        put_all(8'h3C, '0, 1'b0);
        step("R5 restart");
        check_eq("R5 lane4 restarts at seed", lane_out(4), {1'b0, 8'h3C ^ ks_of(16'hFFFE)});
        check_eq("R7 count over 16 runs lane12", lane_out(12), {1'b0, 8'h3C ^ ks_of(16'hFFFE)});
        lane_count = 5'd0;
        put_pat(330, '0, 1'b0);
        step("R7 stop latency");
        check_eq("R7 lane0 still runs one cycle", lane_out(0), m_hist[0][0]);
        put_pat(331, '0, 1'b0);
        step("R7 stopped");
        check_eq("R7 lane0 idle after stop", lane_out(0), 9'h000);
        for (int c = 0; c < 8; c++) begin
            put_pat(c + 340, '0, 1'b0);
            step("R7 all off");
        end
    endtask

    task automatic t_skew();   // R6
        int first [NL];
        lane_count = 5'd16;
        put_all(8'h00, '1, 1'b0);
        for (int c = 0; c < 8; c++) step("R6 flush");
        for (int l = 0; l < NL; l++) first[l] = -1;
        put_all(8'hA5, '1, 1'b0);
        for (int k = 1; k <= 9; k++) begin
            step("R6 walk");
            put_all(8'h00, '1, 1'b0);
            for (int l = 0; l < NL; l++)
                if (first[l] < 0 && lane_out(l) == {1'b1, 8'hA5}) first[l] = k;
        end
        for (int l = 0; l < NL; l++)
            check_eq($sformatf("R6 latency lane %0d", l), 9'(first[l]), 9'(1 + 2 * (l % 4)));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 after release");
        t_first_data();
        t_ctrl();
        t_reseed();
        t_lanes();
        t_skew();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule